// File: doc/BRIEF.md
# Page-mode parallel ROM reader

This block sits between a synchronous host and an external asynchronous parallel ROM that can serve fast reads within a page. The host presents one read at a time with a valid/ready handshake and later receives the data with a one-cycle valid strobe. The controller drives the ROM's chip-enable, output-enable, bus-width select and address pins, waits a cycle count that covers the ROM's access time, and then registers the data bus.

The controller remembers which page is open. A read whose upper address bits match the open page, under the same bus width and with the chip still enabled, waits only the short in-page delay. Any other read waits the full random-access delay. In byte mode the ROM's top data pin turns into the lowest address input, so the controller drives it. Before driving that pin after a switch from word mode, the controller waits for the ROM's output drivers to float. The chip is released after a programmable number of idle cycles, and the page is then closed. All delays are parameters in clock cycles, each at least 1.

Top module: `prom_page_reader`

## Requirements
- R1: While and right after reset: rom_ce_n=1, rom_oe_n=1, rom_d15_oe=0, rom_byte_n=1 (word mode), rsp_valid=0, req_ready=1.
- R2: A read that misses the open page, under an unchanged bus width, raises rsp_valid exactly RAND_CYC cycles after the accepting clock edge. rom_addr holds steady for the whole wait.
- R3: A read whose page tag (ROM word address bits above PAGE_W) matches the open page, with the chip still enabled and the width unchanged, raises rsp_valid exactly PAGE_CYC cycles after acceptance.
- R4: In word mode (req_byte=0), rom_addr = req_addr[ADDR_W-1:0] and rsp_data returns all DQ_W bits of rom_dq_i.
- R5: In byte mode (req_byte=1), rom_byte_n=0, rom_addr = req_addr[ADDR_W:1], rom_d15_oe=1 with rom_d15_o = req_addr[0], and rsp_data = zero upper half with rom_dq_i[DQ_W/2-1:0] in the low half.
- R6: A read whose width differs from the current width first holds rom_ce_n=1, rom_oe_n=1 and rom_d15_oe=0 for FLOAT_CYC cycles, then performs a random access. Total latency is FLOAT_CYC+RAND_CYC. The top data pin is never driven while the ROM may still be driving it.
- R7: Both enables are low whenever rsp_valid is high, and rsp_valid lasts exactly one cycle per read.
- R8: After IDLE_CYC idle cycles with the chip enabled, rom_ce_n and rom_oe_n go high and the page closes, so the next read is a random access even within the same page.
- R9: req_ready is low from the accepting edge until the response, so only one read is outstanding.
- R10: The page is closed after reset, so the first read is a random access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host read request |
| req_addr | input | ADDR_W+1 | Read address: a word index in word mode, a byte index in byte mode |
| req_byte | input | 1 | 1 selects byte-wide read |
| req_ready | output | 1 | Controller can accept a request |
| rsp_valid | output | 1 | One-cycle data-valid strobe |
| rsp_data | output | DQ_W | Read data |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_byte_n | output | 1 | ROM width select, low for byte mode |
| rom_addr | output | ADDR_W | ROM word address pins |
| rom_d15_o | output | 1 | Value driven on the shared top data pin in byte mode |
| rom_d15_oe | output | 1 | Output enable for the shared top data pin |
| rom_dq_i | input | DQ_W | ROM data bus |

## Verification
The bench ROM model returns correct data only after the address has been stable for the random delay and the low bits for the page delay. A controller that samples too early, or that takes a miss for a hit, returns a poison value, and its latency count also disagrees with the expected one. Width switches are checked in both directions. A controller that drives the shared pin without the float gap is caught by a contention monitor, and one that returns upper byte lanes in byte mode fails the data compare. An idle gap longer than the release count, followed by a read in the same page, exposes a controller that keeps the page open after releasing the chip.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_WAIT   = 2'd2
  } rd_state_e;
endpackage

// File: rtl/prom_wait_timer.sv
module prom_wait_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R2: the count only moves down while not reloaded
  p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/prom_page_tracker.sv
module prom_page_tracker #(
  parameter int TAG_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_set,
  input  logic             close,
  input  logic [TAG_W-1:0] set_tag,
  input  logic [TAG_W-1:0] cmp_tag,
  output logic             hit
);
  logic             open_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst || close) begin
      open_q <= 1'b0;
    end else if (open_set) begin
      open_q <= 1'b1;
      tag_q  <= set_tag;
    end
  end

  assign hit = open_q && (tag_q == cmp_tag);

  // R8: a close always leaves no page open
  p_closed_after_release_r8: assert property (@(posedge clk) disable iff (rst)
    close |=> !hit);
endmodule

// File: rtl/prom_page_reader.sv
module prom_page_reader
  import prom_rd_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DQ_W      = 16,
  parameter int PAGE_W    = 3,
  parameter int RAND_CYC  = 4,
  parameter int PAGE_CYC  = 2,
  parameter int FLOAT_CYC = 1,
  parameter int IDLE_CYC  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W:0]   req_addr,
  input  logic              req_byte,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DQ_W-1:0]   rsp_data,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  output logic              rom_byte_n,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_d15_o,
  output logic              rom_d15_oe,
  input  logic [DQ_W-1:0]   rom_dq_i
);
  localparam int LANE_W   = DQ_W / 2;
  localparam int TAG_W    = ADDR_W - PAGE_W;
  localparam int MAX_A    = (RAND_CYC > PAGE_CYC) ? RAND_CYC : PAGE_CYC;
  localparam int MAX_WAIT = (MAX_A > FLOAT_CYC) ? MAX_A : FLOAT_CYC;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int IDLE_W   = $clog2(IDLE_CYC + 1);

  rd_state_e          state_q;
  logic               mode_q;
  logic [IDLE_W-1:0]  idle_q;
  logic [ADDR_W-1:0]  word_addr;
  logic               accept, mode_chg, hit, ce_on, idle_expire;
  logic               t_load, t_zero, pg_set, pg_close;
  logic [CNT_W-1:0]   t_val;

  assign req_ready   = (state_q == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign word_addr   = req_byte ? req_addr[ADDR_W:1] : req_addr[ADDR_W-1:0];
  assign mode_chg    = (req_byte != mode_q);
  assign ce_on       = !rom_ce_n;
  assign idle_expire = req_ready && !accept && ce_on &&
                       (idle_q == IDLE_W'(IDLE_CYC - 1));
  assign pg_set      = (state_q == ST_WAIT) && t_zero;
  assign pg_close    = idle_expire || (accept && mode_chg);

  prom_page_tracker #(.TAG_W(TAG_W)) u_page (
    .clk      (clk),
    .rst      (rst),
    .open_set (pg_set),
    .close    (pg_close),
    .set_tag  (rom_addr[ADDR_W-1:PAGE_W]),
    .cmp_tag  (word_addr[ADDR_W-1:PAGE_W]),
    .hit      (hit)
  );

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    case (state_q)
      ST_IDLE: if (accept) begin
        t_load = 1'b1;
        if (mode_chg)  t_val = CNT_W'(FLOAT_CYC - 1);
        else if (hit)  t_val = CNT_W'(PAGE_CYC - 1);
        else           t_val = CNT_W'(RAND_CYC - 1);
      end
      ST_SETTLE: if (t_zero) begin
        t_load = 1'b1;
        t_val  = CNT_W'(RAND_CYC - 1);
      end
      default: ;
    endcase
  end

  prom_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      mode_q     <= 1'b0;
      idle_q     <= '0;
      rom_ce_n   <= 1'b1;
      rom_oe_n   <= 1'b1;
      rom_byte_n <= 1'b1;
      rom_addr   <= '0;
      rom_d15_o  <= 1'b0;
      rom_d15_oe <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            idle_q    <= '0;
            rom_addr  <= word_addr;
            rom_d15_o <= req_byte & req_addr[0];
            if (mode_chg) begin
              rom_ce_n   <= 1'b1;
              rom_oe_n   <= 1'b1;
              rom_d15_oe <= 1'b0;
              rom_byte_n <= !req_byte;
              mode_q     <= req_byte;
              state_q    <= ST_SETTLE;
            end else begin
              rom_ce_n <= 1'b0;
              rom_oe_n <= 1'b0;
              state_q  <= ST_WAIT;
            end
          end else if (idle_expire) begin
            rom_ce_n <= 1'b1;
            rom_oe_n <= 1'b1;
            idle_q   <= '0;
          end else if (ce_on) begin
            idle_q <= idle_q + 1'b1;
          end
        end
        ST_SETTLE: if (t_zero) begin
          rom_ce_n   <= 1'b0;
          rom_oe_n   <= 1'b0;
          rom_d15_oe <= mode_q;
          state_q    <= ST_WAIT;
        end
        ST_WAIT: if (t_zero) begin
          rsp_valid <= 1'b1;
          rsp_data  <= mode_q ? {{(DQ_W-LANE_W){1'b0}}, rom_dq_i[LANE_W-1:0]}
                              : rom_dq_i;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7: data is captured only with both enables low
  p_rsp_enabled_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (!rom_ce_n && !rom_oe_n));
  // R7: one-cycle strobe
  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R9: a response follows a busy cycle
  p_busy_before_rsp_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(!req_ready));
  // R2: address pins hold while a read is in flight
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> $stable(rom_addr));
  // R5: shared pin is driven only in byte mode
  p_d15_byte_only_r5: assert property (@(posedge clk) disable iff (rst)
    rom_d15_oe |-> !rom_byte_n);
  // R6: during the float gap the shared pin is released
  p_settle_released_r6: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && rom_ce_n) |-> (!rom_d15_oe && rom_oe_n));
endmodule

// File: tb/prom_page_reader_tb.sv
module prom_page_reader_tb;
  localparam int AW = 12;
  localparam int R  = 4;
  localparam int P  = 2;
  localparam int F  = 2;
  localparam int IC = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AW:0] req_addr = '0;
  logic req_byte = 1'b0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_data;
  logic rom_ce_n, rom_oe_n, rom_byte_n, rom_d15_o, rom_d15_oe;
  logic [AW-1:0] rom_addr;
  logic [15:0] rom_dq;

  int errors = 0, checks = 0, cyc = 0, clash = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  prom_page_reader #(.ADDR_W(AW), .DQ_W(16), .PAGE_W(3), .RAND_CYC(R),
    .PAGE_CYC(P), .FLOAT_CYC(F), .IDLE_CYC(IC)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_byte(req_byte), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
    .rom_byte_n(rom_byte_n), .rom_addr(rom_addr), .rom_d15_o(rom_d15_o),
    .rom_d15_oe(rom_d15_oe), .rom_dq_i(rom_dq));

  function automatic logic [15:0] f16(input logic [AW-1:0] a);
    return 16'((32'(a) * 32'd40503) ^ 32'h3C5A);
  endfunction
  function automatic logic [7:0] f8(input logic [AW:0] b);
    return 8'((32'(b) * 32'd37) ^ 32'h6D);
  endfunction

  // ROM model: data is valid only after the access times have elapsed
  logic [7:0] rand_age = 8'hFF, page_age = 8'hFF, off_age = 8'hFF;
  logic [AW-3:0] prev_hi = '0;
  logic [3:0] prev_lo = '0;
  logic prev_ce = 1'b1, prev_bn = 1'b1;
  logic rom_drv;
  assign rom_drv = !rom_ce_n && !rom_oe_n && rom_byte_n;

  always @(negedge clk) begin
    if (rom_ce_n || rom_addr[AW-1:3] != prev_hi || rom_ce_n != prev_ce ||
        rom_byte_n != prev_bn)
      rand_age <= rom_ce_n ? 8'd0 : 8'd1;
    else if (rand_age != 8'hFF) rand_age <= rand_age + 8'd1;
    if ({rom_addr[2:0], rom_d15_o} != prev_lo || rom_addr[AW-1:3] != prev_hi)
      page_age <= 8'd1;
    else if (page_age != 8'hFF) page_age <= page_age + 8'd1;
    if (rom_drv) off_age <= 8'd0;
    else if (off_age != 8'hFF) off_age <= off_age + 8'd1;
    if (rom_d15_oe && (rom_drv || off_age < 8'(F))) clash <= clash + 1;
    prev_hi <= rom_addr[AW-1:3];
    prev_lo <= {rom_addr[2:0], rom_d15_o};
    prev_ce <= rom_ce_n;
    prev_bn <= rom_byte_n;
  end

  always_comb begin
    if (rom_ce_n || rom_oe_n || rand_age < 8'(R) || page_age < 8'(P))
      rom_dq = 16'hBAD0;
    else if (rom_byte_n)
      rom_dq = f16(rom_addr);
    else
      rom_dq = {rom_d15_o, 7'h55, f8({rom_addr, rom_d15_o})};
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // scoreboard
  logic [15:0] q_data[$];
  int q_acc[$], q_lat[$];
  string q_rq[$];
  bit prev_rsp = 0;

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q_data.size() == 0) check(0, "R7 unexpected response", 1, 0);
      else begin
        automatic logic [15:0] ed = q_data.pop_front();
        automatic int acc = q_acc.pop_front();
        automatic int lat = q_lat.pop_front();
        automatic string rq = q_rq.pop_front();
        check(rsp_data == ed, {rq, " data"}, rsp_data, ed);
        check(cyc - acc == lat, {rq, " latency"}, cyc - acc, lat);
        check(!rom_ce_n && !rom_oe_n, "R7 enables at response", {rom_ce_n, rom_oe_n}, 0);
      end
      if (prev_rsp) check(0, "R7 strobe longer than one cycle", 1, 0);
    end
    prev_rsp <= rsp_valid;
  end

  task automatic rd(input logic [AW:0] addr, input bit bm, input int lat, input string rq);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_byte = bm;
    q_data.push_back(bm ? {8'h00, f8(addr)} : f16(addr[AW-1:0]));
    q_acc.push_back(cyc + 1);
    q_lat.push_back(lat);
    q_rq.push_back(rq);
    @(negedge clk);
    req_valid = 1'b0;
    if (lat > 1) check(req_ready == 1'b0, "R9 ready while busy", req_ready, 0);
    while (q_data.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rom_ce_n && rom_oe_n && !rom_d15_oe && rom_byte_n && !rsp_valid && req_ready,
          "R1 reset state", {rom_ce_n, rom_oe_n, rom_d15_oe, rom_byte_n, rsp_valid, req_ready}, 6'b110101);
    rst = 1'b0;
    @(negedge clk);
    check(rom_ce_n && req_ready, "R1 after reset", {rom_ce_n, req_ready}, 2'b11);
    rd(13'h010, 0, R, "R10 first read random");
    check(rom_addr == 12'h010, "R4 word address pins", rom_addr, 12'h010);
    rd(13'h013, 0, P, "R3 page hit");
    rd(13'h017, 0, P, "R3 page hit top word");
    rd(13'h018, 0, R, "R2 page miss");
    repeat (IC + 4) @(negedge clk);
    check(rom_ce_n && rom_oe_n, "R8 standby after idle", {rom_ce_n, rom_oe_n}, 2'b11);
    rd(13'h019, 0, R, "R8 same page after release is random");
    rd(13'h031, 1, F + R, "R6 word to byte switch");
    check(rom_d15_oe && !rom_byte_n && rom_d15_o && rom_addr == 12'h018,
          "R5 byte pins", {rom_d15_oe, rom_byte_n, rom_d15_o}, 3'b101);
    rd(13'h03E, 1, P, "R5 byte page hit");
    check(!rom_d15_o && rom_addr == 12'h01F, "R5 A-1 low", rom_d15_o, 0);
    rd(13'h040, 1, R, "R5 byte page miss");
    rd(13'h020, 0, F + R, "R6 byte to word switch");
    check(!rom_d15_oe && rom_byte_n, "R6 shared pin released", {rom_d15_oe, rom_byte_n}, 2'b01);
    rd(13'h021, 0, P, "R4 word hit full width");
    check(clash == 0, "R6 shared pin contention", clash, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule